// File: doc/BRIEF.md
# Dual Data Pointer Unit

This unit keeps two pointer registers for an 8-bit microcontroller core and chooses which of them the current pointer instruction works on. The core's decoder hands over one-cycle strobes for five pointer instructions:

- increment
- load of a full-width immediate
- indexed code read, which uses the pointer plus the accumulator
- external read through the pointer
- external write through the pointer

The unit answers with the memory address that the instruction needs, and it updates the chosen register on the next clock edge.

A select flag names the active pointer. A toggle-enable flag lets every pointer instruction flip that select flag once the instruction has used the active pointer. With toggling on, back-to-back instructions reach the two pointers in turn, and software does not have to rewrite the select flag between them. Software reaches both pointers and the control flags through a small byte-wide register port. Writes are synchronous. Reads are combinational.

All pins are plain control and data pins. There is no flow control, because every strobe completes in the cycle it is given. The unit never pushes back on the core.

Top module: `dptr_unit`

## Requirements
- R1: After reset both pointers, the select flag and the toggle-enable flag are all 0.
- R2: When the select flag is 0, pointer 0 is active; when it is 1, pointer 1 is active. addr_out always shows the active pointer, except during an indexed code read. An instruction never changes the inactive pointer.
- R3: An increment strobe adds one to the full width of the active pointer on the next edge, and 16'hFFFF wraps to 16'h0000.
- R4: A load strobe writes load_val into the active pointer on the next edge, in one cycle. The pointer used is the one that was active before any toggle. If load and increment come together, load wins.
- R5: During an indexed code read strobe, addr_out is the active pointer plus the zero-extended accumulator, modulo 2^16. During an external read or write strobe, addr_out is the active pointer. addr_valid is 1 exactly while one of these three strobes is high.
- R6: When the toggle-enable flag is 1, any cycle with at least one of the five instruction strobes high inverts the select flag on the next edge. Starting from select 0, two increments step pointer 0 and then pointer 1, and leave select at 0.
- R7: When the toggle-enable flag is 0, the select flag changes only through a software write to the control register.
- R8: A software write to the control register in the same cycle as a toggling instruction sets the flags to the written value, and no toggle happens.
- R9: The register index sw_idx is encoded as follows. Control register bits above 1 read as 0.

  | sw_idx | Register |
  |---|---|
  | 0 | pointer 0 low byte |
  | 1 | pointer 0 high byte |
  | 2 | pointer 1 low byte |
  | 3 | pointer 1 high byte |
  | 4 | control: bit 0 = select, bit 1 = toggle enable |

  Writes take effect on the next edge. sw_rdata shows the indexed register in the same cycle.
- R10: A software write to a pointer byte in the same cycle as an instruction update of that pointer takes the written byte. The other byte takes the instruction's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_inc | input | 1 | Increment strobe |
| op_load | input | 1 | Load-immediate strobe |
| op_movc | input | 1 | Indexed code read strobe |
| op_movx_rd | input | 1 | External read strobe |
| op_movx_wr | input | 1 | External write strobe |
| load_val | input | 16 | Immediate value for load |
| acc | input | 8 | Accumulator value for indexed read |
| addr_out | output | 16 | Address from the active pointer |
| addr_valid | output | 1 | High during a code read or external access strobe |
| sw_we | input | 1 | Software register write enable |
| sw_idx | input | 3 | Software register index |
| sw_wdata | input | 8 | Software write data |
| sw_rdata | output | 8 | Software read data |
| sel_out | output | 1 | Current select flag |
| tsl_out | output | 1 | Current toggle-enable flag |

## Verification
The hardest situations to reach from the ports are two same-cycle collisions. In the first, a software write to the control register meets an instruction that would toggle. In the second, a byte write meets an increment or load of the same pointer. In both, the bench drives the software port and an instruction strobe in one cycle and reads every register back afterwards.

The bench also sweeps both flag values, both select values and all five strobes from preloaded distinct pointer values. It covers every accumulator value against a pointer close to 16'hFFFF, so the indexed address is seen to wrap.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    UPD_HOLD = 2'd0,
    UPD_INC  = 2'd1,
    UPD_LOAD = 2'd2
  } upd_e;
endpackage

// File: rtl/dptr_reg.sv
module dptr_reg
  import dptr_pkg::*;
#(
  parameter int PTR_W = 16,
  localparam int NBYTES = PTR_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  upd_e              upd,
  input  logic [PTR_W-1:0]  load_val,
  input  logic [NBYTES-1:0] byte_we,
  input  logic [BYTE_W-1:0] wdata,
  output logic [PTR_W-1:0]  q
);
  logic [PTR_W-1:0] nxt;

  always_comb begin
    case (upd)
      UPD_LOAD: nxt = load_val;
      UPD_INC:  nxt = q + {{(PTR_W-1){1'b0}}, 1'b1};
      default:  nxt = q;
    endcase
    for (int b = 0; b < NBYTES; b++) begin
      if (byte_we[b]) nxt[b*BYTE_W +: BYTE_W] = wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/dptr_sel_ctrl.sv
module dptr_sel_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       any_op,
  input  logic       ctrl_we,
  input  logic [1:0] ctrl_wdata,
  output logic       sel_q,
  output logic       tsl_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      tsl_q <= 1'b0;
    end else if (ctrl_we) begin
      sel_q <= ctrl_wdata[0];
      tsl_q <= ctrl_wdata[1];
    end else if (tsl_q && any_op) begin
      sel_q <= ~sel_q;
    end
  end
endmodule

// File: rtl/dptr_addr_gen.sv
module dptr_addr_gen #(
  parameter int PTR_W = 16,
  parameter int ACC_W = 8
) (
  input  logic [PTR_W-1:0] active_ptr,
  input  logic [ACC_W-1:0] acc,
  input  logic             op_movc,
  input  logic             op_movx,
  output logic [PTR_W-1:0] addr_out,
  output logic             addr_valid
);
  logic [PTR_W-1:0] acc_ext;

  assign acc_ext    = {{(PTR_W-ACC_W){1'b0}}, acc};
  assign addr_out   = op_movc ? active_ptr + acc_ext : active_ptr;
  assign addr_valid = op_movc | op_movx;
endmodule

// File: rtl/dptr_unit.sv
module dptr_unit
  import dptr_pkg::*;
#(
  parameter int PTR_W = 16,
  parameter int ACC_W = 8,
  localparam int NBYTES = PTR_W / BYTE_W,
  localparam int CTRL_IDX = 2 * NBYTES,
  localparam int IDX_W = $clog2(CTRL_IDX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_inc,
  input  logic              op_load,
  input  logic              op_movc,
  input  logic              op_movx_rd,
  input  logic              op_movx_wr,
  input  logic [PTR_W-1:0]  load_val,
  input  logic [ACC_W-1:0]  acc,
  output logic [PTR_W-1:0]  addr_out,
  output logic              addr_valid,
  input  logic              sw_we,
  input  logic [IDX_W-1:0]  sw_idx,
  input  logic [BYTE_W-1:0] sw_wdata,
  output logic [BYTE_W-1:0] sw_rdata,
  output logic              sel_out,
  output logic              tsl_out
);
  logic [PTR_W-1:0] dp_q [2];
  logic             sel_q, tsl_q;
  logic             any_op, ctrl_we;
  upd_e             op_upd;
  logic [PTR_W-1:0] active_ptr;

  assign any_op  = op_inc | op_load | op_movc | op_movx_rd | op_movx_wr;
  assign ctrl_we = sw_we && (sw_idx == IDX_W'(CTRL_IDX));
  assign op_upd  = op_load ? UPD_LOAD : (op_inc ? UPD_INC : UPD_HOLD);

  for (genvar p = 0; p < 2; p++) begin : g_ptr
    logic [NBYTES-1:0] byte_we;
    upd_e              upd;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      assign byte_we[b] = sw_we && (sw_idx == IDX_W'(p*NBYTES + b));
    end

    assign upd = (sel_q == p[0]) ? op_upd : UPD_HOLD;

    dptr_reg #(.PTR_W(PTR_W)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd      (upd),
      .load_val (load_val),
      .byte_we  (byte_we),
      .wdata    (sw_wdata),
      .q        (dp_q[p])
    );
  end

  dptr_sel_ctrl u_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .any_op     (any_op),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (sw_wdata[1:0]),
    .sel_q      (sel_q),
    .tsl_q      (tsl_q)
  );

  assign active_ptr = sel_q ? dp_q[1] : dp_q[0];

  dptr_addr_gen #(.PTR_W(PTR_W), .ACC_W(ACC_W)) u_addr (
    .active_ptr (active_ptr),
    .acc        (acc),
    .op_movc    (op_movc),
    .op_movx    (op_movx_rd | op_movx_wr),
    .addr_out   (addr_out),
    .addr_valid (addr_valid)
  );

  always_comb begin
    sw_rdata = '0;
    for (int p = 0; p < 2; p++) begin
      for (int b = 0; b < NBYTES; b++) begin
        if (sw_idx == IDX_W'(p*NBYTES + b)) sw_rdata = dp_q[p][b*BYTE_W +: BYTE_W];
      end
    end
    if (sw_idx == IDX_W'(CTRL_IDX)) sw_rdata = {{(BYTE_W-2){1'b0}}, tsl_q, sel_q};
  end

  assign sel_out = sel_q;
  assign tsl_out = tsl_q;
endmodule

// File: rtl/dptr_unit_chk.sv
module dptr_unit_chk #(
  parameter int PTR_W = 16,
  parameter int IDX_W = 3,
  parameter int CTRL_IDX = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_inc,
  input logic             op_load,
  input logic             op_movc,
  input logic             op_movx_rd,
  input logic             op_movx_wr,
  input logic [PTR_W-1:0] load_val,
  input logic             sw_we,
  input logic [IDX_W-1:0] sw_idx,
  input logic [7:0]       sw_wdata,
  input logic             sel_out,
  input logic             tsl_out,
  input logic             addr_valid,
  input logic [PTR_W-1:0] p0,
  input logic [PTR_W-1:0] p1
);
  logic             any_op, ctrl_wr;
  logic [PTR_W-1:0] act_p, idle_p;

  assign any_op  = op_inc | op_load | op_movc | op_movx_rd | op_movx_wr;
  assign ctrl_wr = sw_we && (sw_idx == IDX_W'(CTRL_IDX));
  assign act_p   = sel_out ? p1 : p0;
  assign idle_p  = sel_out ? p0 : p1;

  a_r6_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (tsl_out && any_op && !ctrl_wr) |=> (sel_out != $past(sel_out)));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tsl_out && !ctrl_wr) |=> $stable(sel_out));

  a_r8_sw_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (sel_out == $past(sw_wdata[0]) && tsl_out == $past(sw_wdata[1])));

  a_r3_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (op_inc && !op_load && !sw_we) |=>
      (($past(sel_out) ? p1 : p0) == PTR_W'($past(act_p) + 1)));

  a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
    (op_load && !sw_we) |=> (($past(sel_out) ? p1 : p0) == $past(load_val)));

  a_r2_idle_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (any_op && !sw_we) |=> (($past(sel_out) ? p0 : p1) == $past(idle_p)));

  a_r5_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (op_inc || op_load) && !(op_movc || op_movx_rd || op_movx_wr) |-> !addr_valid);
endmodule

bind dptr_unit dptr_unit_chk #(.PTR_W(PTR_W), .IDX_W(IDX_W), .CTRL_IDX(CTRL_IDX)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_inc     (op_inc),
  .op_load    (op_load),
  .op_movc    (op_movc),
  .op_movx_rd (op_movx_rd),
  .op_movx_wr (op_movx_wr),
  .load_val   (load_val),
  .sw_we      (sw_we),
  .sw_idx     (sw_idx),
  .sw_wdata   (sw_wdata),
  .sel_out    (sel_out),
  .tsl_out    (tsl_out),
  .addr_valid (addr_valid),
  .p0         (dp_q[0]),
  .p1         (dp_q[1])
);

// File: tb/dptr_unit_test.sv
`timescale 1ns/100ps
module dptr_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_inc = 0, op_load = 0, op_movc = 0, op_movx_rd = 0, op_movx_wr = 0;
  logic [15:0] load_val = '0;
  logic [7:0]  acc = '0;
  logic [15:0] addr_out;
  logic        addr_valid;
  logic        sw_we = 0;
  logic [2:0]  sw_idx = '0;
  logic [7:0]  sw_wdata = '0;
  logic [7:0]  sw_rdata;
  logic        sel_out, tsl_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] m_dp [2];
  logic        m_sel, m_tsl;

  always #2.5 clk = ~clk;

  dptr_unit uut (
    .clk(clk), .rst_n(rst_n), .op_inc(op_inc), .op_load(op_load), .op_movc(op_movc),
    .op_movx_rd(op_movx_rd), .op_movx_wr(op_movx_wr), .load_val(load_val), .acc(acc),
    .addr_out(addr_out), .addr_valid(addr_valid), .sw_we(sw_we), .sw_idx(sw_idx),
    .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .sel_out(sel_out), .tsl_out(tsl_out)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock cycle: drive at negedge, check combinational address, update model at edge.
  task automatic step(logic i, logic l, logic c, logic r, logic w, logic [15:0] lv,
                      logic [7:0] a, logic we, logic [2:0] idx, logic [7:0] wd);
    logic [15:0] exp_addr;
    logic        act;
    @(negedge clk);
    op_inc = i; op_load = l; op_movc = c; op_movx_rd = r; op_movx_wr = w;
    load_val = lv; acc = a; sw_we = we; sw_idx = idx; sw_wdata = wd;
    #0.5;
    act = m_sel;
    exp_addr = c ? m_dp[act] + {8'h00, a} : m_dp[act];
    chk("R5 addr", addr_out, exp_addr);
    chk("R5 valid", {15'd0, addr_valid}, {15'd0, c | r | w});
    @(posedge clk);
    if (l) m_dp[act] = lv;
    else if (i) m_dp[act] = m_dp[act] + 16'd1;
    if (we && idx < 3'd4) begin
      if (idx[0]) m_dp[idx[1]][15:8] = wd;
      else        m_dp[idx[1]][7:0]  = wd;
    end
    if (we && idx == 3'd4) begin
      m_sel = wd[0]; m_tsl = wd[1];
    end else if (m_tsl && (i | l | c | r | w)) begin
      m_sel = ~m_sel;
    end
    #0.1;
    op_inc = 0; op_load = 0; op_movc = 0; op_movx_rd = 0; op_movx_wr = 0; sw_we = 0;
  endtask

  task automatic swr(logic [2:0] idx, logic [7:0] wd);
    step(0, 0, 0, 0, 0, 16'h0, 8'h0, 1, idx, wd);
  endtask

  task automatic check_state(string tag);
    @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      logic [7:0] e;
      sw_idx = 3'(k);
      #0.2;
      case (k)
        0: e = m_dp[0][7:0];
        1: e = m_dp[0][15:8];
        2: e = m_dp[1][7:0];
        3: e = m_dp[1][15:8];
        default: e = {6'd0, m_tsl, m_sel};
      endcase
      chk({tag, " R9 reg"}, {8'h00, sw_rdata}, {8'h00, e});
    end
    chk({tag, " R2 sel"}, {15'd0, sel_out}, {15'd0, m_sel});
    chk({tag, " R2 active addr"}, addr_out, m_sel ? m_dp[1] : m_dp[0]);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_dp[0] = '0; m_dp[1] = '0; m_sel = 0; m_tsl = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    check_state("R1 reset");
    chk("R1 tsl", {15'd0, tsl_out}, 16'd0);

    // R6 sweep over flags and every strobe from distinct pointer values.
    for (int t = 0; t < 2; t++) begin
      for (int s = 0; s < 2; s++) begin
        for (int op = 0; op < 5; op++) begin
          swr(3'd0, 8'h34); swr(3'd1, 8'h12); swr(3'd2, 8'hCD); swr(3'd3, 8'hAB);
          swr(3'd4, {6'd0, 1'(t), 1'(s)});
          step(op == 0, op == 1, op == 2, op == 3, op == 4, 16'h5A00 + 16'(op),
               8'hF0, 0, 3'd0, 8'h0);
          check_state(t ? "R6 toggle sweep" : "R7 no toggle sweep");
        end
      end
    end

    // R6 two increments alternate pointers and return select to 0.
    swr(3'd4, 8'h02);
    step(1, 0, 0, 0, 0, 16'h0, 8'h0, 0, 3'd0, 8'h0);
    step(1, 0, 0, 0, 0, 16'h0, 8'h0, 0, 3'd0, 8'h0);
    check_state("R6 inc pair");

    // R3 wrap of full width, on each pointer.
    swr(3'd4, 8'h00);
    step(0, 1, 0, 0, 0, 16'hFFFF, 8'h0, 0, 3'd0, 8'h0);
    step(1, 0, 0, 0, 0, 16'h0, 8'h0, 0, 3'd0, 8'h0);
    check_state("R3 wrap p0");
    swr(3'd4, 8'h01);
    step(0, 1, 0, 0, 0, 16'hFFFF, 8'h0, 0, 3'd0, 8'h0);
    step(1, 0, 0, 0, 0, 16'h0, 8'h0, 0, 3'd0, 8'h0);
    check_state("R3 wrap p1");

    // R4 load beats increment when both strobes are high.
    step(1, 1, 0, 0, 0, 16'h7777, 8'h0, 0, 3'd0, 8'h0);
    check_state("R4 load over inc");

    // R5 every accumulator value against a pointer near the top (wraps).
    swr(3'd4, 8'h00);
    step(0, 1, 0, 0, 0, 16'hFF80, 8'h0, 0, 3'd0, 8'h0);
    for (int a = 0; a < 256; a++) begin
      step(0, 0, 1, 0, 0, 16'h0, 8'(a), 0, 3'd0, 8'h0);
    end
    check_state("R5 acc sweep");

    // R8 control write collides with a toggling instruction.
    swr(3'd4, 8'h02);
    step(1, 0, 0, 0, 0, 16'h0, 8'h0, 1, 3'd4, 8'h02);
    check_state("R8 collide keep");
    step(0, 0, 0, 1, 0, 16'h0, 8'h0, 1, 3'd4, 8'h03);
    check_state("R8 collide set");

    // R10 byte write with increment of the same pointer.
    swr(3'd4, 8'h00);
    step(0, 1, 0, 0, 0, 16'h10FF, 8'h0, 0, 3'd0, 8'h0);
    step(1, 0, 0, 0, 0, 16'h0, 8'h0, 1, 3'd0, 8'h55);
    check_state("R10 low byte wins");
    step(0, 1, 0, 0, 0, 16'hBEEF, 8'h0, 1, 3'd1, 8'h99);
    check_state("R10 high byte wins");

    // R9 unused control bits read back as 0.
    swr(3'd4, 8'hFC);
    check_state("R9 ctrl mask");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule